// File: doc/BRIEF.md
# Prescaled Event Timer with Atomic Wide Access

This block is an up-counter placed on an 8-bit register bus. It counts in one of two widths, 8 or 16 bits. Its count events come from one of two sources. The first is an internal tick that fires once every four system clocks. The second is a rising edge on an external pin, which the block synchronises before use. A power-of-two prescaler sits between the source and the counter, and a bypass bit can skip it. When the counter wraps it raises a sticky flag. The interrupt output is high whenever that flag and its enable bit are both set.

Software never reaches the upper counter byte directly. A read of the low byte copies the live upper byte into a holding register, and that register can then be read at leisure. A write to the holding register changes nothing in the counter. The next write to the low byte loads the holding register and the written byte into the counter together, so a 16-bit value never tears.

Register map (2-bit address):

| Address | Register | Contents |
|---|---|---|
| 0 | control | bit 6 width (1 = 16-bit), bit 5 source (1 = external pin), bit 3 prescaler bypass, bits 2:0 prescaler select; bits 7 and 4 are stored and read back |
| 1 | low count byte | live counter bits 7:0 |
| 2 | upper-byte holding register | read or write |
| 3 | status | bit 0 overflow flag, bit 1 interrupt enable |

Top module: `evtmr_top`

## Requirements
- R1: After reset, the control register, counter, holding register, flag and enable all read as zero, and `irq_o` is low.
- R2: With source bit 0 and bypass set, the counter advances exactly once in every four clock cycles.
- R3: With source bit 1, each rising edge on `ext_pin` produces exactly one count. A pin held high does not count again. The count lands on the third clock edge after the pin is first sampled high.
- R4: With bypass clear, prescaler select code n makes the counter advance once per 2^(n+1) source events. Code 3 (binary 011) therefore divides by 16.
- R5: With bypass set, every source event advances the counter, whatever the select code.
- R6: A write to the low count byte restarts the prescaler from zero.
- R7: In 8-bit mode (control bit 6 = 0), a wrap of the low byte from 0xFF to 0x00 sets the flag. The upper counter byte is left unchanged, and a low-byte write loads the low byte only.
- R8: In 16-bit mode, the flag is set only by the wrap from 0xFFFF to 0x0000.
- R9: Reading address 1 copies the live upper counter byte into the holding register. Address 2 then returns that copy, even if the counter keeps running.
- R10: A write to address 2 loads only the holding register. A later write to address 1 in 16-bit mode loads {holding, written byte} into the counter in a single cycle.
- R11: The flag clears only when a 0 is written to status bit 0. Writing a 1 never sets it. If an overflow and a clearing write happen in the same cycle, the flag ends up set.
- R12: `irq_o` is high exactly when the flag and the enable bit (status bit 1) are both 1.
- R13: If a low-byte write and a count event happen in the same cycle, the written value is loaded and that count event is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; a read of address 1 takes the upper-byte snapshot |
| bus_wdata | input | BYTE_W | Write data |
| bus_rdata | output | BYTE_W | Read data for the current address (combinational) |
| ext_pin | input | 1 | External count input, asynchronous |
| irq_o | output | 1 | Interrupt request |

## Verification
Two pairs of events can fall in the same clock cycle. The first pair is a count event and a low-byte load. The bench raises the external pin two cycles before it issues the write, so the synchronised edge and the write reach the counter on the same edge. It then expects the written byte, with no increment on top. The second pair is a wrap and a status write that clears the flag. The bench aligns these the same way and expects the flag to survive. A behavioural model that runs alongside the design catches any off-by-one in how these events are ordered on every cycle.

// File: rtl/evtmr_pkg.sv
package evtmr_pkg;

   localparam int REG_AW = 2;

   typedef enum logic [REG_AW-1:0] {
      RA_CTRL   = 2'd0,
      RA_CNT_LO = 2'd1,
      RA_HI_BUF = 2'd2,
      RA_STATUS = 2'd3
   } reg_addr_e;

   typedef struct packed {
      logic       spare7;
      logic       wide;
      logic       ext_src;
      logic       spare4;
      logic       bypass;
      logic [2:0] ps_sel;
   } ctrl_t;

   localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/evtmr_tick_src.sv
module evtmr_tick_src #(
   parameter int DIV_LOG2    = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ext_pin,
   input  logic sel_ext,
   output logic tick_o
);

   logic int_tick;
   logic ext_tick;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("evtmr_tick_src: SYNC_STAGES must be at least 2");
   end
   if (DIV_LOG2 < 0) begin : g_bad_div
      $error("evtmr_tick_src: DIV_LOG2 must not be negative");
   end

   if (DIV_LOG2 == 0) begin : g_no_div
      assign int_tick = 1'b1;
   end else begin : g_div
      logic [DIV_LOG2-1:0] div_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) div_q <= '0;
         else        div_q <= div_q + 1'b1;
      end
      assign int_tick = &div_q;
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], ext_pin};
         prev_q <= sync_q[SYNC_STAGES-1];
      end
   end

   assign ext_tick = sync_q[SYNC_STAGES-1] & ~prev_q;
   assign tick_o   = sel_ext ? ext_tick : int_tick;

   // R3: a held level yields a single event
   assert_ext_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ext_tick |=> !ext_tick);

endmodule

// File: rtl/evtmr_prescale.sv
module evtmr_prescale #(
   parameter int SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             src_tick,
   input  logic             clr,
   input  logic             bypass,
   input  logic [SEL_W-1:0] sel,
   output logic             tick_o
);

   localparam int PCNT_W = 2 ** SEL_W;

   if (SEL_W < 1 || SEL_W > 4) begin : g_bad_sel
      $error("evtmr_prescale: SEL_W must lie in 1..4");
   end

   logic [PCNT_W-1:0] pcnt_q;
   logic [PCNT_W-1:0] mask;

   always_comb begin
      mask = {PCNT_W{1'b1}} >> (PCNT_W - 1 - int'(sel));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pcnt_q <= '0;
      else if (clr)      pcnt_q <= '0;
      else if (src_tick) pcnt_q <= pcnt_q + 1'b1;
   end

   assign tick_o = src_tick & (bypass | ((pcnt_q & mask) == mask));

   // R6: a counter load restarts the division
   assert_clear_restarts_R6: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (pcnt_q == '0));

endmodule

// File: rtl/evtmr_counter.sv
module evtmr_counter #(
   parameter int BYTE_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick,
   input  logic                wide,
   input  logic                wr_lo,
   input  logic                wr_hi,
   input  logic                rd_lo,
   input  logic [BYTE_W-1:0]   wdata,
   output logic [2*BYTE_W-1:0] cnt_o,
   output logic [BYTE_W-1:0]   hbuf_o,
   output logic                ovf_o
);

   localparam int CNT_W = 2 * BYTE_W;

   logic [CNT_W-1:0]  cnt_q;
   logic [BYTE_W-1:0] hbuf_q;
   logic              at_top;

   assign at_top = wide ? (&cnt_q) : (&cnt_q[BYTE_W-1:0]);
   assign ovf_o  = tick & ~wr_lo & at_top;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (wr_lo) begin
         if (wide) cnt_q <= {hbuf_q, wdata};
         else      cnt_q[BYTE_W-1:0] <= wdata;
      end else if (tick) begin
         if (wide) cnt_q <= cnt_q + 1'b1;
         else      cnt_q[BYTE_W-1:0] <= cnt_q[BYTE_W-1:0] + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     hbuf_q <= '0;
      else if (wr_hi) hbuf_q <= wdata;
      else if (rd_lo) hbuf_q <= cnt_q[CNT_W-1:BYTE_W];
   end

   assign cnt_o  = cnt_q;
   assign hbuf_o = hbuf_q;

   // R10: a holding-register write leaves the count alone
   assert_hbuf_write_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hi && !tick && !wr_lo) |=> (cnt_q == $past(cnt_q)));

   // R13: a load wins over a simultaneous event
   assert_load_wins_R13: assert property (@(posedge clk) disable iff (!rst_n)
      wr_lo |=> (cnt_q[BYTE_W-1:0] == $past(wdata)));

   // R7: narrow mode never moves the upper byte except by nothing
   assert_narrow_upper_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !wide |=> (cnt_q[CNT_W-1:BYTE_W] == $past(cnt_q[CNT_W-1:BYTE_W])));

   // R9: a low read captures the live upper byte
   assert_snapshot_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_lo && !wr_hi) |=> (hbuf_q == $past(cnt_q[CNT_W-1:BYTE_W])));

endmodule

// File: rtl/evtmr_top.sv
module evtmr_top
   import evtmr_pkg::*;
#(
   parameter int BYTE_W      = 8,
   parameter int PS_SEL_W    = 3,
   parameter int DIV_LOG2    = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [BYTE_W-1:0] bus_wdata,
   output logic [BYTE_W-1:0] bus_rdata,
   input  logic              ext_pin,
   output logic              irq_o
);

   localparam int CNT_W = 2 * BYTE_W;

   if (BYTE_W < CTRL_W) begin : g_bad_byte
      $error("evtmr_top: BYTE_W must hold the control register");
   end
   if (PS_SEL_W > 3) begin : g_bad_ps
      $error("evtmr_top: PS_SEL_W exceeds the control field");
   end

   ctrl_t       ctrl_q;
   logic        flag_q;
   logic        ie_q;
   logic        wr_ctrl, wr_lo, wr_hi, wr_stat, rd_lo;
   logic        src_tick, cnt_tick, ovf;
   logic [CNT_W-1:0]  cnt;
   logic [BYTE_W-1:0] hbuf;

   assign wr_ctrl = bus_wr & (bus_addr == RA_CTRL);
   assign wr_lo   = bus_wr & (bus_addr == RA_CNT_LO);
   assign wr_hi   = bus_wr & (bus_addr == RA_HI_BUF);
   assign wr_stat = bus_wr & (bus_addr == RA_STATUS);
   assign rd_lo   = bus_rd & (bus_addr == RA_CNT_LO);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q <= '0;
      else if (wr_ctrl) ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         ie_q   <= 1'b0;
      end else begin
         if (wr_stat) ie_q <= bus_wdata[1];
         if (ovf)          flag_q <= 1'b1;
         else if (wr_stat) flag_q <= flag_q & bus_wdata[0];
      end
   end

   evtmr_tick_src #(.DIV_LOG2(DIV_LOG2), .SYNC_STAGES(SYNC_STAGES)) u_src (
      .clk     (clk),
      .rst_n   (rst_n),
      .ext_pin (ext_pin),
      .sel_ext (ctrl_q.ext_src),
      .tick_o  (src_tick)
   );

   evtmr_prescale #(.SEL_W(PS_SEL_W)) u_ps (
      .clk      (clk),
      .rst_n    (rst_n),
      .src_tick (src_tick),
      .clr      (wr_lo),
      .bypass   (ctrl_q.bypass),
      .sel      (ctrl_q.ps_sel[PS_SEL_W-1:0]),
      .tick_o   (cnt_tick)
   );

   evtmr_counter #(.BYTE_W(BYTE_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (cnt_tick),
      .wide   (ctrl_q.wide),
      .wr_lo  (wr_lo),
      .wr_hi  (wr_hi),
      .rd_lo  (rd_lo),
      .wdata  (bus_wdata),
      .cnt_o  (cnt),
      .hbuf_o (hbuf),
      .ovf_o  (ovf)
   );

   always_comb begin
      unique case (bus_addr)
         RA_CTRL:   bus_rdata = BYTE_W'(ctrl_q);
         RA_CNT_LO: bus_rdata = cnt[BYTE_W-1:0];
         RA_HI_BUF: bus_rdata = hbuf;
         default:   bus_rdata = {{(BYTE_W-2){1'b0}}, ie_q, flag_q};
      endcase
   end

   assign irq_o = flag_q & ie_q;

   // R7 R8: a wrap always leaves the flag set
   assert_wrap_sets_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> flag_q);

   // R11: the flag only falls after a clearing write
   assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !(wr_stat && !bus_wdata[0])) |=> flag_q);

   // R11: writing a one cannot create the flag
   assert_no_spurious_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_q && !ovf) |=> !flag_q);

   // R12: the request follows the enable into the next cycle
   assert_irq_needs_enable_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stat && !bus_wdata[1]) |=> !irq_o);

endmodule

// File: tb/tb_evtmr_top.sv
module tb_evtmr_top;

   localparam int CLK_PERIOD = 10;
   localparam int WD_LIMIT   = 100000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic       bus_wr = 1'b0;
   logic       bus_rd = 1'b0;
   logic [7:0] bus_wdata = 8'd0;
   logic [7:0] bus_rdata;
   logic       ext_pin = 1'b0;
   logic       irq_o;

   int    checks = 0;
   int    errors = 0;
   string cur_req = "R1";

   evtmr_top dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .ext_pin   (ext_pin),
      .irq_o     (irq_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int m_div = 0, m_s0 = 0, m_s1 = 0, m_prev = 0, m_pcnt = 0;
   int m_cnt = 0, m_buf = 0, m_flag = 0, m_ie = 0, m_ctrl = 0;
   int t_it, t_et, t_st, t_pt, t_mask, t_old, t_ovf, t_wide;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_div = 0; m_s0 = 0; m_s1 = 0; m_prev = 0; m_pcnt = 0;
         m_cnt = 0; m_buf = 0; m_flag = 0; m_ie = 0; m_ctrl = 0;
      end else begin
         t_it = (m_div == 3);
         m_div = (m_div + 1) % 4;
         t_et = (m_s1 == 1) && (m_prev == 0);
         m_prev = m_s1; m_s1 = m_s0; m_s0 = int'(ext_pin);
         t_wide = (m_ctrl >> 6) & 1;
         t_st = ((m_ctrl >> 5) & 1) ? t_et : t_it;
         t_mask = (1 << ((m_ctrl & 7) + 1)) - 1;
         t_pt = t_st && (((m_ctrl >> 3) & 1) || ((m_pcnt & t_mask) == t_mask));
         if (t_st) m_pcnt = (m_pcnt + 1) % 256;
         t_old = m_cnt;
         t_ovf = 0;
         if (bus_wr && bus_addr == 2'd1) begin
            m_pcnt = 0;
            m_cnt = t_wide ? ((m_buf << 8) | int'(bus_wdata)) : ((m_cnt & 'hFF00) | int'(bus_wdata));
         end else if (t_pt) begin
            if (t_wide) begin
               t_ovf = (m_cnt == 'hFFFF);
               m_cnt = (m_cnt + 1) & 'hFFFF;
            end else begin
               t_ovf = ((m_cnt & 'hFF) == 'hFF);
               m_cnt = (m_cnt & 'hFF00) | ((m_cnt + 1) & 'hFF);
            end
         end
         if (bus_wr && bus_addr == 2'd2) m_buf = int'(bus_wdata);
         else if (bus_rd && bus_addr == 2'd1) m_buf = t_old >> 8;
         if (bus_wr && bus_addr == 2'd3) begin
            m_ie = int'(bus_wdata[1]);
            m_flag = m_flag & int'(bus_wdata[0]);
         end
         if (t_ovf) m_flag = 1;
         if (bus_wr && bus_addr == 2'd0) m_ctrl = int'(bus_wdata);
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         case (bus_addr)
            2'd0:    chk(cur_req, int'(bus_rdata), m_ctrl);
            2'd1:    chk(cur_req, int'(bus_rdata), m_cnt & 'hFF);
            2'd2:    chk(cur_req, int'(bus_rdata), m_buf);
            default: chk(cur_req, int'(bus_rdata), (m_ie << 1) | m_flag);
         endcase
         chk(cur_req, int'(irq_o), m_flag & m_ie);
      end
   end

   // ---------------- stimulus helpers (entered just after a rising edge) ----------------
   task automatic cyc();
      @(posedge clk);
      #1;
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      cyc();
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output int v);
      bus_addr = a; bus_rd = 1'b1;
      #4;
      v = int'(bus_rdata);
      cyc();
      bus_rd = 1'b0;
   endtask

   task automatic pulse();
      ext_pin = 1'b1;
      repeat (3) cyc();
      ext_pin = 1'b0;
      repeat (3) cyc();
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (WD_LIMIT) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int v, a, b;
      // R1: reset values
      repeat (3) @(posedge clk);
      #1;
      for (int i = 0; i < 4; i++) begin
         bus_addr = 2'(i);
         #1;
         if (i != 1) chk("R1", int'(bus_rdata), 0);
      end
      chk("R1", int'(irq_o), 0);
      bus_addr = 2'd0;
      rst_n = 1'b1;
      cyc();
      rd(2'd2, v); chk("R1", v, 0);
      rd(2'd3, v); chk("R1", v, 0);

      // R2: internal source, bypass, 16-bit
      cur_req = "R2";
      wr(2'd0, 8'h48);
      repeat (5) cyc();
      rd(2'd1, a);
      repeat (7) cyc();
      rd(2'd1, b);
      chk("R2", (b - a) & 'hFF, 2);

      // R4: divide by 16 with code 011
      cur_req = "R4";
      wr(2'd0, 8'h43);
      wr(2'd2, 8'h00);
      wr(2'd1, 8'h00);
      repeat (200) cyc();
      rd(2'd1, v); chk("R4", v, 3);
      wr(2'd0, 8'h40);
      repeat (60) cyc();

      // R3: external edges, one count each
      cur_req = "R3";
      wr(2'd0, 8'h68);
      wr(2'd2, 8'h00);
      wr(2'd1, 8'h00);
      repeat (3) pulse();
      rd(2'd1, v); chk("R3", v, 3);
      ext_pin = 1'b1;
      repeat (12) cyc();
      rd(2'd1, v); chk("R3", v, 4);
      ext_pin = 1'b0;
      repeat (3) cyc();

      // R10: holding write does not touch the count; low write commits 16 bits
      cur_req = "R10";
      wr(2'd2, 8'h12);
      rd(2'd2, v); chk("R10", v, 'h12);
      bus_addr = 2'd1; #1; chk("R10", int'(bus_rdata), 4);
      wr(2'd1, 8'h34);
      rd(2'd1, v); chk("R10", v, 'h34);
      rd(2'd2, v); chk("R10", v, 'h12);

      // R9: snapshot replaces a written holding value
      cur_req = "R9";
      wr(2'd2, 8'h56);
      rd(2'd1, v);
      rd(2'd2, v); chk("R9", v, 'h12);

      // R8: 16-bit wrap
      cur_req = "R8";
      wr(2'd3, 8'h00);
      wr(2'd2, 8'hFF);
      wr(2'd1, 8'hFE);
      pulse();
      rd(2'd3, v); chk("R8", v, 0);
      pulse();
      rd(2'd1, v); chk("R8", v, 0);
      rd(2'd2, v); chk("R8", v, 0);
      rd(2'd3, v); chk("R8", v, 1);

      // R12 / R11: enable gating and stickiness
      cur_req = "R12";
      chk("R12", int'(irq_o), 0);
      wr(2'd3, 8'h03);
      chk("R12", int'(irq_o), 1);
      cur_req = "R11";
      wr(2'd3, 8'h02);
      chk("R12", int'(irq_o), 0);
      wr(2'd3, 8'h03);
      rd(2'd3, v); chk("R11", v, 2);

      // R7: 8-bit wrap leaves upper byte
      cur_req = "R7";
      wr(2'd0, 8'h68);
      wr(2'd2, 8'h7A);
      wr(2'd1, 8'hFF);
      wr(2'd0, 8'h28);
      wr(2'd3, 8'h00);
      pulse();
      rd(2'd1, v); chk("R7", v, 0);
      rd(2'd2, v); chk("R7", v, 'h7A);
      rd(2'd3, v); chk("R7", v, 1);
      wr(2'd1, 8'h05);
      rd(2'd1, v);
      rd(2'd2, v); chk("R7", v, 'h7A);

      // R5: prescale vs bypass on external events
      cur_req = "R5";
      wr(2'd0, 8'h20);
      wr(2'd1, 8'h00);
      repeat (4) pulse();
      rd(2'd1, v); chk("R5", v, 2);
      wr(2'd0, 8'h28);
      repeat (4) pulse();
      rd(2'd1, v); chk("R5", v, 6);

      // R6: load restarts the prescaler
      cur_req = "R6";
      wr(2'd0, 8'h20);
      wr(2'd1, 8'h10);
      pulse();
      wr(2'd1, 8'h10);
      pulse();
      rd(2'd1, v); chk("R6", v, 'h10);
      pulse();
      rd(2'd1, v); chk("R6", v, 'h11);

      // R11: overflow and clearing write in the same cycle
      cur_req = "R11";
      wr(2'd0, 8'h28);
      wr(2'd3, 8'h02);
      wr(2'd1, 8'hFF);
      ext_pin = 1'b1;
      cyc(); cyc();
      wr(2'd3, 8'h02);
      ext_pin = 1'b0;
      repeat (3) cyc();
      rd(2'd3, v); chk("R11", v, 3);
      chk("R12", int'(irq_o), 1);

      // R13: load and count event in the same cycle
      cur_req = "R13";
      ext_pin = 1'b1;
      cyc(); cyc();
      wr(2'd1, 8'h40);
      ext_pin = 1'b0;
      repeat (3) cyc();
      rd(2'd1, v); chk("R13", v, 'h40);

      // free run across prescale codes against the model
      cur_req = "R4";
      for (int c = 0; c < 3; c++) begin
         wr(2'd0, 8'(8'h40 | c));
         repeat (80) cyc();
      end
      repeat (2) cyc();
      finish_run();
   end

endmodule